// File: doc/BRIEF.md
# Byte-Serial Register Command Decoder

This block takes register-write commands that arrive one byte per clock on an 8-bit bus. Each command is a frame of six bytes. The first byte is marked by a start flag. The block gathers a 16-bit address and a 32-bit data word from the frame. It then checks the address against a base value, comparing only the bits selected by a mask. When the address matches, the block presents a small register index and the data word, together with a write pulse that lasts one cycle. The register file behind the block uses that index to pick which of its registers to write.

Several functions can sit on the same command bus, each behind its own decoder with its own base address. A frame addressed to some other function passes through this block with no effect: it gives no pulse and leaves the index and data outputs as they were. If a new start flag arrives before a frame is complete, the partial frame is thrown away and assembly begins again.

Top module: `bytecmd_decoder`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, `wr_en` is 0, `wr_index` is 0 and `wr_data` is 0, and no frame is in progress.
- R2: A frame is the byte flagged by `cmd_first`, followed by five bytes on the next five clocks. Together they are, in order: address bits 7:0, address bits 15:8, then data bits 7:0, 15:8, 23:16 and 31:24.
- R3: A frame is accepted when `(address & 16'h03F8) == (16'h0160 & 16'h03F8)`. Address bits outside the mask, including bits 15:10, are not compared.
- R4: On an accepted frame, `wr_index` equals address bits 2:0 and `wr_data` equals the assembled 32-bit word.
- R5: `wr_en` is high for exactly one cycle. It rises at the clock edge after the edge that captures the last data byte, which is six edges after the edge that captures the flagged byte. `wr_index` and `wr_data` take their new values at that same edge.
- R6: When `cmd_first` is asserted while a frame is incomplete, the partial frame is discarded. The flagged byte becomes address bits 7:0 of a new frame.
- R7: Bytes that arrive without `cmd_first` while no frame is in progress are ignored. A frame that is not accepted gives no pulse, and `wr_index` and `wr_data` keep their previous values.
- R8: A new flagged byte on the clock right after the last byte of a frame starts the next frame. Both frames are decoded.
- R9: A reset in the middle of a frame discards that frame. Bytes that follow the reset without `cmd_first` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic acts on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte | input | 8 | Command byte stream |
| cmd_first | input | 1 | Marks the first byte (address bits 7:0) of a frame |
| wr_index | output | 3 | Register index taken from the decoded address |
| wr_data | output | 32 | Assembled data word |
| wr_en | output | 1 | One-cycle write pulse for an accepted frame |

## Verification
A wrong byte position, such as a stuck or skipped lane, shows up as a scrambled `wr_data` or `wr_index` on the pulse that ends the affected frame. That pulse comes six clocks after the flag. A fault in the match logic shows up at the same moment, either as a missing pulse or as a spurious one. A sequencer that fails to restart, or fails to go idle, does not show up at once. It first appears as a pulse that comes at the wrong clock, or that never comes, one frame length later. For that reason the bench compares all three outputs against its model on every clock instead of only on pulses.

// File: rtl/bytecmd_pkg.sv
package bytecmd_pkg;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_BUSY = 1'b1
  } frame_state_e;

  localparam int unsigned DEF_BYTE_W     = 8;
  localparam int unsigned DEF_ADDR_BYTES = 2;
  localparam int unsigned DEF_DATA_BYTES = 4;

endpackage

// File: rtl/bytecmd_seq.sv
module bytecmd_seq
  import bytecmd_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 first,
  output logic [FRAME_LEN-1:0] lane_en,
  output logic                 frame_done
);

  localparam int unsigned CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  frame_state_e     state;
  logic [CNT_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FR_IDLE;
      pos        <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (first) begin
        state <= FR_BUSY;
        pos   <= CNT_W'(1);
      end else if (state == FR_BUSY) begin
        if (pos == LAST_POS) begin
          state      <= FR_IDLE;
          pos        <= '0;
          frame_done <= 1'b1;
        end else begin
          pos <= pos + CNT_W'(1);
        end
      end
    end
  end

  for (genvar i = 0; i < FRAME_LEN; i++) begin : g_lane_sel
    if (i == 0) begin : g_head
      assign lane_en[i] = first;
    end else begin : g_tail
      assign lane_en[i] = !first && (state == FR_BUSY) && (pos == CNT_W'(i));
    end
  end

  // R2: at most one byte lane is written per clock
  p_one_lane_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_en));

  // R6: a flagged byte always restarts at the second position
  p_first_restarts_r6: assert property (@(posedge clk) disable iff (rst)
    first |=> (state == FR_BUSY && pos == CNT_W'(1)));

  // R7: no frame completes without passing through the last lane
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(lane_en[FRAME_LEN-1]));

endmodule

// File: rtl/bytecmd_lanes.sv
module bytecmd_lanes #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [BYTE_W-1:0]        byte_in,
  input  logic [LANES-1:0]         lane_en,
  output logic [BYTE_W*LANES-1:0]  frame_bits
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (lane_en[i]) begin
        lane_q <= byte_in;
      end
    end

    assign frame_bits[i*BYTE_W +: BYTE_W] = lane_q;

    // R2: a selected lane holds the byte presented with its enable
    p_lane_capture_r2: assert property (@(posedge clk) disable iff (rst)
      lane_en[i] |=> (lane_q == $past(byte_in)));
  end

endmodule

// File: rtl/bytecmd_match.sv
module bytecmd_match #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned BASE_ADDR = 'h160,
  parameter int unsigned ADDR_MASK = 'h3F8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_index,
  output logic [DATA_W-1:0] wr_data
);

  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] MASK_V = ADDR_W'(ADDR_MASK);

  logic hit;
  assign hit = ((addr ^ BASE_V) & MASK_V) == '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_index <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= frame_done && hit;
      if (frame_done && hit) begin
        wr_index <= addr[IDX_W-1:0];
        wr_data  <= data;
      end
    end
  end

  // R5: the write pulse never lasts longer than one cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R5: a pulse is always preceded by a completed frame
  p_pulse_after_frame_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(frame_done));

  // R7: outputs hold whenever no write is issued
  p_hold_data_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> ($stable(wr_data) && $stable(wr_index)));

  // R3: a completed frame with a matching address always yields a pulse
  p_hit_pulses_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (((addr ^ BASE_V) & MASK_V) == '0)) |=> wr_en);

endmodule

// File: rtl/bytecmd_decoder.sv
module bytecmd_decoder
  import bytecmd_pkg::*;
#(
  parameter int unsigned BYTE_W     = DEF_BYTE_W,
  parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES,
  parameter int unsigned DATA_BYTES = DEF_DATA_BYTES,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned BASE_ADDR  = 'h160,
  parameter int unsigned ADDR_MASK  = 'h3F8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [BYTE_W-1:0]            cmd_byte,
  input  logic                         cmd_first,
  output logic [IDX_W-1:0]             wr_index,
  output logic [BYTE_W*DATA_BYTES-1:0] wr_data,
  output logic                         wr_en
);

  localparam int unsigned FRAME_LEN = ADDR_BYTES + DATA_BYTES;
  localparam int unsigned ADDR_W    = BYTE_W * ADDR_BYTES;
  localparam int unsigned DATA_W    = BYTE_W * DATA_BYTES;
  localparam int unsigned FRAME_W   = BYTE_W * FRAME_LEN;

  logic [FRAME_LEN-1:0] lane_en;
  logic                 frame_done;
  logic [FRAME_W-1:0]   frame_bits;

  bytecmd_seq #(
    .FRAME_LEN (FRAME_LEN)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .first      (cmd_first),
    .lane_en    (lane_en),
    .frame_done (frame_done)
  );

  bytecmd_lanes #(
    .BYTE_W (BYTE_W),
    .LANES  (FRAME_LEN)
  ) u_lanes (
    .clk        (clk),
    .rst        (rst),
    .byte_in    (cmd_byte),
    .lane_en    (lane_en),
    .frame_bits (frame_bits)
  );

  bytecmd_match #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .BASE_ADDR (BASE_ADDR),
    .ADDR_MASK (ADDR_MASK)
  ) u_match (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .addr       (frame_bits[ADDR_W-1:0]),
    .data       (frame_bits[FRAME_W-1:ADDR_W]),
    .wr_en      (wr_en),
    .wr_index   (wr_index),
    .wr_data    (wr_data)
  );

  // R1: the cycle after reset shows no pulse
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> !wr_en);

  // R9: a reset leaves no completed frame behind it
  p_reset_flush_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !frame_done);

endmodule

// File: tb/bytecmd_decoder_test.sv
module bytecmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd_byte = '0;
  logic        cmd_first = 1'b0;
  logic [2:0]  wr_index;
  logic [31:0] wr_data;
  logic        wr_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done_flag = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [7:0]  q[$];
  logic        m_we = 1'b0;
  logic [2:0]  m_idx = '0;
  logic [31:0] m_data = '0;
  bit          pend = 1'b0;
  logic [15:0] pend_addr = '0;
  logic [31:0] pend_data = '0;

  always #4 clk = ~clk;

  bytecmd_decoder uut (
    .clk       (clk),
    .rst       (rst),
    .cmd_byte  (cmd_byte),
    .cmd_first (cmd_first),
    .wr_index  (wr_index),
    .wr_data   (wr_data),
    .wr_en     (wr_en)
  );

  function automatic bit accepted(input logic [15:0] a);
    return (a & 16'h03F8) == (16'h0160 & 16'h03F8);
  endfunction

  task automatic model_edge(input logic r, input logic s, input logic [7:0] b);
    if (r) begin
      q.delete();
      m_we = 1'b0; m_idx = '0; m_data = '0; pend = 1'b0;
    end else begin
      m_we = pend && accepted(pend_addr);
      if (m_we) begin
        m_idx  = pend_addr[2:0];
        m_data = pend_data;
      end
      pend = 1'b0;
      if (s) begin
        q.delete();
        q.push_back(b);
      end else if (q.size() > 0) begin
        q.push_back(b);
        if (q.size() == 6) begin
          pend_addr = {q[1], q[0]};
          pend_data = {q[5], q[4], q[3], q[2]};
          pend = 1'b1;
          q.delete();
        end
      end
    end
  endtask

  task automatic cyc(input logic r, input logic s, input logic [7:0] b);
    @(negedge clk);
    checks++;
    if (wr_en !== m_we || wr_index !== m_idx || wr_data !== m_data) begin
      failures++;
      $display("FAIL %s t=%0t actual we=%0b idx=%0d data=%h expected we=%0b idx=%0d data=%h",
               cur_req, $time, wr_en, wr_index, wr_data, m_we, m_idx, m_data);
    end
    rst = r; cmd_first = s; cmd_byte = b;
    model_edge(r, s, b);
  endtask

  task automatic send(input logic [15:0] a, input logic [31:0] d);
    cyc(0, 1, a[7:0]);
    cyc(0, 0, a[15:8]);
    for (int k = 0; k < 4; k++) cyc(0, 0, d[8*k +: 8]);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 8'(k * 37 + 5));
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual cycles=%0d expected below 20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    cyc(1, 0, 8'h00); cyc(1, 1, 8'h60); cyc(1, 0, 8'h01);
    cyc(0, 0, 8'h00); idle(2);

    // R2 / R5: byte order and pulse timing
    cur_req = "R2";
    send(16'h0165, 32'hA1B2C3D4); idle(3);
    cur_req = "R5";
    send(16'h0160, 32'h01020304); idle(4);

    // R4: every index value
    cur_req = "R4";
    for (int i = 0; i < 8; i++) begin
      send(16'h0160 + 16'(i), 32'h5A000000 ^ (32'(i) * 32'h01010101));
      idle(1);
    end

    // R3: mask behaviour, upper bits ignored, neighbours rejected
    cur_req = "R3";
    send(16'hFC63, 32'hCAFEF00D); idle(2);
    send(16'h0168, 32'h11111111); idle(2);
    send(16'h0060, 32'h22222222); idle(2);
    send(16'h0360, 32'h33333333); idle(2);
    send(16'h8167, 32'h44444444); idle(2);

    // R7: unflagged bytes while idle, rejected frame holds outputs
    cur_req = "R7";
    idle(9);
    send(16'h0158, 32'hDEADBEEF); idle(3);

    // R6: restart in the middle and at the last byte position
    cur_req = "R6";
    cyc(0, 1, 8'h61); cyc(0, 0, 8'h01); cyc(0, 0, 8'h99);
    send(16'h0162, 32'h0BADC0DE); idle(2);
    cyc(0, 1, 8'h63); cyc(0, 0, 8'h01);
    cyc(0, 0, 8'h10); cyc(0, 0, 8'h20); cyc(0, 0, 8'h30);
    send(16'h0166, 32'h76543210); idle(2);

    // R8: back-to-back frames
    cur_req = "R8";
    send(16'h0161, 32'hAAAA5555);
    send(16'h0167, 32'h5555AAAA);
    send(16'h0164, 32'h12345678); idle(3);

    // R9: reset mid-frame, trailing bytes ignored
    cur_req = "R9";
    cyc(0, 1, 8'h65); cyc(0, 0, 8'h01); cyc(0, 0, 8'hEE); cyc(0, 0, 8'hDD);
    cyc(1, 0, 8'hCC); cyc(1, 0, 8'hBB);
    cyc(0, 0, 8'hAA); cyc(0, 0, 8'h99); idle(4);
    send(16'h0163, 32'hFEEDFACE); idle(3);

    finish_run();
  end

endmodule